// File: doc/BRIEF.md
# Disjoint Path Selector with Fault Retry

This block sits at one source port of a multistage network that offers three disjoint paths between any source and destination. For each request it receives the three precomputed routing tags (upper, middle, lower). It chooses which one to launch, based on the request class (synchronous or asynchronous), whether the destination is a hot spot, and whether tree saturation is currently signalled. The chosen tag, its path index and a set of per-path reservation bits are presented on registered outputs, together with a one-cycle send strobe.

When the fabric reports a fault on the path in use, the packet is considered returned to the source. The selector relaunches it on the next disjoint path that has not failed yet, using the tags captured when the request was accepted. Since the paths share no switch or link, two faults can always be absorbed. A third fault exhausts the set: the selector raises a one-cycle unreachable pulse and drops the request. A new request may be presented at any time. It replaces the held one and starts with a clean failure record.

Top module: `dps_path_select`

## Requirements
- R1: While reset is high and on the first cycle after it, `active`, `send_valid`, `unreachable`, `resv` and `path_idx` are all zero.
- R2: A cycle with `req_valid` high accepts a request. On the next cycle `send_valid` is high for exactly one cycle and `active` is high.
- R3: Path indices are encoded as 0 = upper, 1 = middle, 2 = lower. With `sat` low at acceptance, path 0 is launched with `tag_up` and `resv` is 3'b000.
- R4: With `sat` high and `req_sync` high, path 0 is launched and `resv` is 3'b000.
- R5: With `sat` high, `req_sync` low and `dst_hot` low, path 1 (middle) is launched. `resv` is 3'b001, which keeps the upper path (bit 0) free for synchronous traffic.
- R6: With `sat` high, `req_sync` low and `dst_hot` high, path 0 is launched. `resv` is 3'b110, which holds the middle (bit 1) and lower (bit 2) paths for other asynchronous requests.
- R7: A `fault_pulse` while a request is active relaunches it one cycle later on the first path not yet failed. The search order is 1,2,0 for a request accepted under R5 and 0,1,2 otherwise. The tag used is the one captured at acceptance; later changes on the tag inputs have no effect.
- R8: The third fault on one request gives a one-cycle `unreachable` pulse with `send_valid` low. `active` drops on that same cycle, and no path is launched twice for that request.
- R9: Accepting a new request clears the failed-path record, so the new request again gets three attempts.
- R10: A `fault_pulse` while no request is active is ignored: neither `send_valid` nor `unreachable` rises.
- R11: When `req_valid` and `fault_pulse` are high in the same cycle, the new request is accepted and the fault is ignored. The new request starts with no failed path.
- R12: `resv` is unchanged across retries of a request and returns to 3'b000 when the request is dropped as unreachable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Present a new request (accepted in the same cycle) |
| req_sync | input | 1 | 1 = synchronous request, 0 = asynchronous |
| dst_hot | input | 1 | Destination is a hot spot |
| sat | input | 1 | Tree saturation currently signalled |
| fault_pulse | input | 1 | Fault returned on the path in use |
| tag_up | input | TAG_W | Routing tag of the upper path |
| tag_mid | input | TAG_W | Routing tag of the middle path |
| tag_low | input | TAG_W | Routing tag of the lower path |
| send_valid | output | 1 | One-cycle strobe: launch `send_tag` |
| send_tag | output | TAG_W | Tag of the selected path |
| path_idx | output | 2 | Selected path (0 upper, 1 middle, 2 lower) |
| resv | output | 3 | Reservation bits, bit i for path i |
| active | output | 1 | A request is held |
| unreachable | output | 1 | One-cycle pulse: all three paths failed, request dropped |

## Verification
A fresh request and a fault report for the request already held can arrive in the same cycle. That collision is where acceptance and retry compete for the same state. The bench provokes it after a request has already lost one path. It raises `req_valid` and `fault_pulse` together and checks that the new request launches its own first-choice path. It then checks that the following faults walk all three paths before `unreachable` appears, which shows that the colliding fault neither marked a path nor consumed an attempt.

// File: rtl/dps_pkg.sv
package dps_pkg;
  localparam int NPATH = 3;
  localparam int IDX_W = 2;
  typedef logic [IDX_W-1:0] path_idx_t;
  localparam path_idx_t P_UP  = 2'd0;
  localparam path_idx_t P_MID = 2'd1;
  localparam path_idx_t P_LOW = 2'd2;
endpackage

// File: rtl/dps_classify.sv
module dps_classify
  import dps_pkg::*;
(
  input  logic             sat,
  input  logic             req_sync,
  input  logic             dst_hot,
  output logic             mid_first,
  output logic [NPATH-1:0] resv_new
);
  always_comb begin
    mid_first = 1'b0;
    resv_new  = '0;
    if (sat && !req_sync) begin
      if (dst_hot) begin
        resv_new[P_MID] = 1'b1;
        resv_new[P_LOW] = 1'b1;
      end else begin
        mid_first       = 1'b1;
        resv_new[P_UP]  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dps_pick.sv
module dps_pick
  import dps_pkg::*;
(
  input  logic [NPATH-1:0] fail_mask,
  input  logic             mid_first,
  output path_idx_t        pick_idx,
  output logic             pick_none
);
  always_comb begin
    int p;
    pick_idx  = P_UP;
    pick_none = 1'b1;
    for (int k = NPATH - 1; k >= 0; k--) begin
      p = mid_first ? ((k + 1) % NPATH) : k;
      if (!fail_mask[p]) begin
        pick_idx  = path_idx_t'(p);
        pick_none = 1'b0;
      end
    end
  end
endmodule

// File: rtl/dps_tag_bank.sv
module dps_tag_bank
  import dps_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic                   clk,
  input  logic                   wr_en,
  input  logic [NPATH*TAG_W-1:0] wr_tags,
  input  path_idx_t              rd_idx,
  output logic [TAG_W-1:0]       rd_tag
);
  logic [TAG_W-1:0] mem [NPATH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int i = 0; i < NPATH; i++) mem[i] <= wr_tags[i*TAG_W +: TAG_W];
    end
  end

  always_comb begin
    rd_tag = '0;
    for (int i = 0; i < NPATH; i++)
      if (rd_idx == path_idx_t'(i)) rd_tag = mem[i];
  end
endmodule

// File: rtl/dps_path_select.sv
module dps_path_select
  import dps_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_sync,
  input  logic             dst_hot,
  input  logic             sat,
  input  logic             fault_pulse,
  input  logic [TAG_W-1:0] tag_up,
  input  logic [TAG_W-1:0] tag_mid,
  input  logic [TAG_W-1:0] tag_low,
  output logic             send_valid,
  output logic [TAG_W-1:0] send_tag,
  output logic [1:0]       path_idx,
  output logic [2:0]       resv,
  output logic             active,
  output logic             unreachable
);
  localparam int FLAT_W = NPATH * TAG_W;

  logic [FLAT_W-1:0] tags_flat;
  logic [NPATH-1:0]  cur_oh, fail_q, fail_next, pk_mask, cls_resv;
  logic              mode_q, cls_mid, pk_mode, pk_none, fault_hit, all_failed;
  path_idx_t         pk_idx;
  logic [TAG_W-1:0]  bank_tag, in_sel, new_tag;

  assign tags_flat = {tag_low, tag_mid, tag_up};

  for (genvar g = 0; g < NPATH; g++) begin : g_oh
    assign cur_oh[g] = (path_idx == path_idx_t'(g));
  end

  assign fault_hit  = fault_pulse && active && !req_valid;
  assign fail_next  = fail_q | cur_oh;
  assign all_failed = &fail_next;
  assign pk_mask    = req_valid ? '0 : fail_next;
  assign pk_mode    = req_valid ? cls_mid : mode_q;

  dps_classify u_cls (
    .sat       (sat),
    .req_sync  (req_sync),
    .dst_hot   (dst_hot),
    .mid_first (cls_mid),
    .resv_new  (cls_resv)
  );

  dps_pick u_pick (
    .fail_mask (pk_mask),
    .mid_first (pk_mode),
    .pick_idx  (pk_idx),
    .pick_none (pk_none)
  );

  dps_tag_bank #(.TAG_W(TAG_W)) u_bank (
    .clk     (clk),
    .wr_en   (req_valid),
    .wr_tags (tags_flat),
    .rd_idx  (pk_idx),
    .rd_tag  (bank_tag)
  );

  always_comb begin
    in_sel = '0;
    for (int i = 0; i < NPATH; i++)
      if (pk_idx == path_idx_t'(i)) in_sel = tags_flat[i*TAG_W +: TAG_W];
    new_tag = req_valid ? in_sel : bank_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      send_valid  <= 1'b0;
      send_tag    <= '0;
      path_idx    <= '0;
      resv        <= '0;
      active      <= 1'b0;
      unreachable <= 1'b0;
      mode_q      <= 1'b0;
      fail_q      <= '0;
    end else begin
      send_valid  <= 1'b0;
      unreachable <= 1'b0;
      if (req_valid) begin
        active     <= 1'b1;
        mode_q     <= cls_mid;
        fail_q     <= '0;
        resv       <= cls_resv;
        path_idx   <= pk_idx;
        send_tag   <= new_tag;
        send_valid <= 1'b1;
      end else if (fault_hit) begin
        fail_q <= fail_next;
        if (all_failed || pk_none) begin
          active      <= 1'b0;
          unreachable <= 1'b1;
          resv        <= '0;
        end else begin
          path_idx   <= pk_idx;
          send_tag   <= new_tag;
          send_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dps_path_select_chk.sv
module dps_path_select_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_sync,
  input logic       dst_hot,
  input logic       sat,
  input logic       fault_pulse,
  input logic       send_valid,
  input logic       active,
  input logic       unreachable,
  input logic [1:0] path_idx,
  input logic [2:0] resv
);
  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!active && !send_valid && !unreachable && resv == 3'b000)); // R1
  AST_ACCEPT_SEND: assert property (@(posedge clk) disable iff (rst) req_valid |=> (send_valid && active)); // R2
  AST_MID_FIRST: assert property (@(posedge clk) disable iff (rst) (req_valid && sat && !req_sync && !dst_hot) |=> (path_idx == 2'd1 && resv == 3'b001)); // R5
  AST_HOT_UPPER: assert property (@(posedge clk) disable iff (rst) (req_valid && sat && !req_sync && dst_hot) |=> (path_idx == 2'd0 && resv == 3'b110)); // R6
  AST_RETRY_MOVES: assert property (@(posedge clk) disable iff (rst) (fault_pulse && active && !req_valid) |=> (unreachable || (send_valid && path_idx != $past(path_idx)))); // R7
  AST_DROP_QUIET: assert property (@(posedge clk) disable iff (rst) unreachable |-> (!active && !send_valid)); // R8
  AST_IDLE_FAULT: assert property (@(posedge clk) disable iff (rst) (fault_pulse && !active && !req_valid) |=> (!send_valid && !unreachable)); // R10
  AST_RESV_HOLD: assert property (@(posedge clk) disable iff (rst) (active && !req_valid) |=> (unreachable || $stable(resv))); // R12
endmodule

bind dps_path_select dps_path_select_chk chk_i (.*);

// File: tb/dps_path_select_tb.sv
module dps_path_select_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TAG_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_sync = 1'b0, dst_hot = 1'b0, sat = 1'b0, fault_pulse = 1'b0;
  logic [TAG_W-1:0] tag_up = 8'hA1, tag_mid = 8'hB2, tag_low = 8'hC3;
  logic send_valid, active, unreachable;
  logic [TAG_W-1:0] send_tag;
  logic [1:0] path_idx;
  logic [2:0] resv;
  int n_checks = 0;
  int n_err = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dps_path_select #(.TAG_W(TAG_W)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_sync(req_sync), .dst_hot(dst_hot),
    .sat(sat), .fault_pulse(fault_pulse), .tag_up(tag_up), .tag_mid(tag_mid), .tag_low(tag_low),
    .send_valid(send_valid), .send_tag(send_tag), .path_idx(path_idx), .resv(resv),
    .active(active), .unreachable(unreachable)
  );

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic request(input logic s, input logic h, input logic st);
    req_valid = 1'b1; req_sync = s; dst_hot = h; sat = st;
    cyc();
    req_valid = 1'b0; sat = 1'b0;
  endtask

  task automatic fault();
    fault_pulse = 1'b1;
    cyc();
    fault_pulse = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 active", active, 0);
    check("R1 send_valid", send_valid, 0);
    check("R1 unreachable", unreachable, 0);
    check("R1 resv", resv, 0);
    check("R1 path_idx", path_idx, 0);
  endtask

  task automatic t_nosat();
    request(1'b0, 1'b0, 1'b0);
    check("R2 send_valid", send_valid, 1);
    check("R2 active", active, 1);
    check("R3 path_idx", path_idx, 0);
    check("R3 tag", send_tag, 8'hA1);
    check("R3 resv", resv, 3'b000);
    cyc();
    check("R2 one-cycle strobe", send_valid, 0);
  endtask

  task automatic t_sync_sat();
    request(1'b1, 1'b1, 1'b1);
    check("R4 path_idx", path_idx, 0);
    check("R4 tag", send_tag, 8'hA1);
    check("R4 resv", resv, 3'b000);
  endtask

  task automatic t_async_nonhot();
    request(1'b0, 1'b0, 1'b1);
    check("R5 path_idx", path_idx, 1);
    check("R5 tag", send_tag, 8'hB2);
    check("R5 resv", resv, 3'b001);
    tag_up = 8'h11; tag_mid = 8'h22; tag_low = 8'h33;
    cyc();
    fault();
    check("R7 send_valid", send_valid, 1);
    check("R7 path_idx lower", path_idx, 2);
    check("R7 stored tag", send_tag, 8'hC3);
    check("R12 resv held", resv, 3'b001);
    fault();
    check("R7 path_idx upper", path_idx, 0);
    check("R7 stored tag upper", send_tag, 8'hA1);
    fault();
    check("R8 unreachable", unreachable, 1);
    check("R8 send_valid", send_valid, 0);
    check("R8 active", active, 0);
    check("R12 resv cleared", resv, 3'b000);
    cyc();
    check("R8 pulse one cycle", unreachable, 0);
    tag_up = 8'hA1; tag_mid = 8'hB2; tag_low = 8'hC3;
  endtask

  task automatic t_idle_fault();
    fault();
    check("R10 send_valid", send_valid, 0);
    check("R10 unreachable", unreachable, 0);
    check("R10 active", active, 0);
  endtask

  task automatic t_hot();
    request(1'b0, 1'b1, 1'b1);
    check("R6 path_idx", path_idx, 0);
    check("R6 resv", resv, 3'b110);
    fault();
    check("R7 hot retry middle", path_idx, 1);
    check("R7 hot tag", send_tag, 8'hB2);
    fault();
    check("R7 hot retry lower", path_idx, 2);
    check("R12 hot resv held", resv, 3'b110);
    fault();
    check("R8 hot unreachable", unreachable, 1);
  endtask

  task automatic t_clear();
    request(1'b0, 1'b0, 1'b0);
    fault();
    fault();
    check("R9 pre path", path_idx, 2);
    request(1'b0, 1'b0, 1'b0);
    check("R9 new path", path_idx, 0);
    fault();
    check("R9 retry allowed", send_valid, 1);
    check("R9 retry path", path_idx, 1);
    check("R9 not unreachable", unreachable, 0);
  endtask

  task automatic t_collide();
    request(1'b1, 1'b0, 1'b0);
    fault();
    check("R11 setup path", path_idx, 1);
    req_valid = 1'b1; fault_pulse = 1'b1; req_sync = 1'b0; dst_hot = 1'b0; sat = 1'b1;
    cyc();
    req_valid = 1'b0; fault_pulse = 1'b0; sat = 1'b0;
    check("R11 send_valid", send_valid, 1);
    check("R11 path_idx", path_idx, 1);
    check("R11 unreachable", unreachable, 0);
    fault();
    check("R11 fresh retry lower", path_idx, 2);
    fault();
    check("R11 fresh retry upper", path_idx, 0);
    check("R11 still active", active, 1);
    fault();
    check("R11 third fault drops", unreachable, 1);
  endtask

  initial begin
    repeat (3) cyc();
    t_reset();
    rst = 1'b0;
    cyc();
    t_reset();
    t_nosat();
    t_sync_sat();
    t_async_nonhot();
    t_idle_fault();
    t_hot();
    t_clear();
    t_collide();
    cyc();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_err++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end
endmodule